// File: doc/BRIEF.md
# Way-Lockable Four-Way Cache Controller

A 16 KB cache controller that is indexed and tagged with physical addresses. It is organised as 128 sets of four ways, and each line holds 32 bytes, which is four 64-bit doublewords. The CPU side presents one request at a time: a read or a write of one doubleword. A hit completes in the cycle the request is presented. A miss stalls the CPU until the memory side has moved the data. The cache is write-back. A line that has been written is marked dirty, and when such a line is evicted it is copied out as a four-beat burst before the new line is filled, also as a four-beat burst.

The victim is the least recently used line, but the choice is limited to the ways that are not locked. A lock setting of `n` reserves ways `0` to `n-1`. Lines resident in those ways are never replaced, so code or data placed there stays in the cache. When all four ways are locked, a miss is served as a single-beat memory access and no line is allocated. Hits, including writes to locked lines, are still served from the cache. A one-cycle invalidate-all pulse sweeps every set in turn and discards all lines and their dirty data. It leaves the lock setting unchanged.

Top module: `wlcache`

## Requirements
- R1: A read or write that hits is completed with `cpu_ready` high in the same cycle as the request, with no stall. Address bits [4:3] select the doubleword within the line, and bits [2:0] are ignored.
- R2: A read always returns the most recently written value of its doubleword. A write that hits updates only the cache and causes no memory traffic.
- R3: A miss that can allocate fetches the line as four read beats with `mem_burst`=1. The beats go to the line base address plus 0, 8, 16 and 24, in that order. The request then completes as a hit.
- R4: If the chosen victim is valid and dirty, its four doublewords are written to memory as a burst at the victim's own line address before the fill starts.
- R5: The victim is the lowest-numbered invalid unlocked way if one exists. Otherwise it is the least recently used unlocked way. Both hits and fills count as uses.
- R6: `lock_ways`=n, with n from 0 to 3, protects ways 0 to n-1: lines held in those ways remain resident however many misses occur. New lines fill invalid ways from way 0 upward.
- R7: With `lock_ways` of 4 or more, a miss becomes one single-beat access (`mem_burst`=0) that reads or writes memory directly, and no line is allocated. Hits are still served, and a write that hits updates the cached line.
- R8: A one-cycle `inv_all` pulse starts a sweep of 128 cycles. During the sweep `cpu_ready` and `mem_req` stay low. After the sweep every line is invalid and any dirty data has been dropped.
- R9: After reset, `cpu_ready` and `mem_req` are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request present; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Physical byte address |
| cpu_wdata | input | 64 | Write doubleword |
| cpu_rdata | output | 64 | Read doubleword, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| lock_ways | input | 3 | Number of locked low ways (4 or more = all) |
| inv_all | input | 1 | Pulse to invalidate all lines |
| mem_req | output | 1 | Memory beat request, held until `mem_valid` |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_burst | output | 1 | 1 = beat belongs to a four-beat line transfer |
| mem_addr | output | 32 | Doubleword-aligned beat address |
| mem_wdata | output | 64 | Write beat data |
| mem_rdata | input | 64 | Read beat data, valid with `mem_valid` |
| mem_valid | input | 1 | Beat accepted or returned this cycle |

## Verification
A hit is due combinationally: `cpu_ready` and the read data are sampled shortly after the falling edge on which the request is driven, and the write lands on the next rising edge. A clean miss completes one cycle after the fourth fill beat is accepted, a dirty miss four beats later than that, and a fully locked miss in the same cycle as its single `mem_valid`. The bench therefore measures each request's latency in whole cycles and samples only on falling edges. The invalidate check requires a request issued just after the pulse to wait at least 127 cycles and then to refill.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
    localparam int WAYS        = 4;
    localparam int LINE_BYTES  = 32;
    localparam int CACHE_BYTES = 16384;
    localparam int DW          = 64;
    localparam int AW          = 32;

    localparam int BEATS  = LINE_BYTES / (DW / 8);
    localparam int SETS   = CACHE_BYTES / (LINE_BYTES * WAYS);
    localparam int BYTE_W = $clog2(DW / 8);
    localparam int BEAT_W = $clog2(BEATS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = AW - IDX_W - BEAT_W - BYTE_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LOCK_W = $clog2(WAYS) + 1;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [BEAT_W-1:0] beat_t;
    typedef logic [DW-1:0]     word_t;

    typedef struct packed {
        tag_t               tag;
        idx_t               idx;
        beat_t              beat;
        logic [BYTE_W-1:0]  byte_off;
    } paddr_t;

    typedef enum logic [2:0] {ST_IDLE, ST_WB, ST_FILL, ST_SINGLE, ST_INV} state_e;

    function automatic logic [AW-1:0] join_addr(input tag_t t, input idx_t i, input beat_t b);
        return {t, i, b, {BYTE_W{1'b0}}};
    endfunction

    function automatic way_t onehot_to_way(input logic [WAYS-1:0] v);
        way_t r = '0;
        for (int w = 0; w < WAYS; w++)
            if (v[w]) r = way_t'(w);
        return r;
    endfunction

    // Invalid unlocked way first (lowest index), else the oldest unlocked way.
    function automatic way_t pick_victim(input way_t [WAYS-1:0] ages,
                                         input logic [WAYS-1:0] valid,
                                         input logic [LOCK_W-1:0] nlock);
        way_t v    = way_t'(WAYS - 1);
        way_t best = '0;
        logic found = 1'b0;
        logic seen  = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (w >= int'(nlock) && !valid[w]) begin
                v = way_t'(w);
                found = 1'b1;
            end
        if (!found)
            for (int w = 0; w < WAYS; w++)
                if (w >= int'(nlock) && (!seen || ages[w] > best)) begin
                    best = ages[w];
                    v    = way_t'(w);
                    seen = 1'b1;
                end
        return v;
    endfunction
endpackage

// File: rtl/wlc_tag_store.sv
module wlc_tag_store
    import wlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  idx_t              rd_idx,
    input  tag_t              rd_tag,
    input  logic              alloc_en,
    input  way_t              alloc_way,
    input  logic              mark_dirty,
    input  way_t              dirty_way,
    input  logic              inv_en,
    input  idx_t              inv_idx,
    output logic [WAYS-1:0]   hit_vec,
    output logic [WAYS-1:0]   valid_vec,
    output logic [WAYS-1:0]   dirty_vec,
    output tag_t [WAYS-1:0]   tag_vec
);
    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
        tag_t            tags_q [SETS];
        logic [SETS-1:0] vld_q;
        logic [SETS-1:0] drt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
                drt_q <= '0;
            end else if (inv_en) begin
                vld_q[inv_idx] <= 1'b0;
                drt_q[inv_idx] <= 1'b0;
            end else if (alloc_en && alloc_way == way_t'(gw)) begin
                vld_q[rd_idx] <= 1'b1;
                drt_q[rd_idx] <= 1'b0;
            end else if (mark_dirty && dirty_way == way_t'(gw)) begin
                drt_q[rd_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk)
            if (alloc_en && alloc_way == way_t'(gw))
                tags_q[rd_idx] <= rd_tag;

        assign valid_vec[gw] = vld_q[rd_idx];
        assign dirty_vec[gw] = drt_q[rd_idx];
        assign tag_vec[gw]   = tags_q[rd_idx];
        assign hit_vec[gw]   = vld_q[rd_idx] && (tags_q[rd_idx] == rd_tag);
    end
endmodule

// File: rtl/wlc_lru_bank.sv
module wlc_lru_bank
    import wlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  idx_t              idx,
    input  logic              touch,
    input  way_t              touch_way,
    input  logic [LOCK_W-1:0] nlock,
    input  logic [WAYS-1:0]   valid_vec,
    output way_t              victim
);
    way_t age_q [SETS][WAYS];
    way_t [WAYS-1:0] cur;

    always_comb
        for (int w = 0; w < WAYS; w++)
            cur[w] = age_q[idx][w];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= way_t'(w);
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++)
                if (way_t'(w) == touch_way)
                    age_q[idx][w] <= '0;
                else if (cur[w] < cur[touch_way])
                    age_q[idx][w] <= cur[w] + way_t'(1);
        end
    end

    assign victim = pick_victim(cur, valid_vec, nlock);
endmodule

// File: rtl/wlcache.sv
module wlcache
    import wlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              cpu_ready,
    input  logic [LOCK_W-1:0] lock_ways,
    input  logic              inv_all,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_burst,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_valid
);
    paddr_t          pa;
    logic [WAYS-1:0] hit_vec, valid_vec, dirty_vec;
    tag_t [WAYS-1:0] tag_vec;
    way_t            hit_way, victim;
    logic            hit, all_locked, last_beat, serve_hit, alloc_en, inv_busy;

    state_e state_q;
    beat_t  beat_q;
    way_t   vict_q;
    tag_t   wbtag_q;
    idx_t   inv_q;

    word_t  data_q [SETS][WAYS][BEATS];
    logic   dat_we;
    way_t   dat_way;
    beat_t  dat_beat;
    word_t  dat_wval;

    assign pa         = paddr_t'(cpu_addr);
    assign hit        = |hit_vec;
    assign hit_way    = onehot_to_way(hit_vec);
    assign all_locked = lock_ways >= LOCK_W'(WAYS);
    assign last_beat  = beat_q == beat_t'(BEATS - 1);
    assign serve_hit  = state_q == ST_IDLE && !inv_all && cpu_req && hit;
    assign alloc_en   = state_q == ST_FILL && mem_valid && last_beat;
    assign inv_busy   = state_q == ST_INV;

    wlc_tag_store u_tags (
        .clk(clk), .rst(rst), .rd_idx(pa.idx), .rd_tag(pa.tag),
        .alloc_en(alloc_en), .alloc_way(vict_q),
        .mark_dirty(serve_hit && cpu_we), .dirty_way(hit_way),
        .inv_en(inv_busy), .inv_idx(inv_q),
        .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec), .tag_vec(tag_vec)
    );

    wlc_lru_bank u_lru (
        .clk(clk), .rst(rst), .idx(pa.idx), .touch(serve_hit), .touch_way(hit_way),
        .nlock(lock_ways), .valid_vec(valid_vec), .victim(victim)
    );

    always_ff @(posedge clk)
        if (dat_we)
            data_q[pa.idx][dat_way][dat_beat] <= dat_wval;

    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = data_q[pa.idx][hit_way][pa.beat];
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_burst = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        dat_we    = 1'b0;
        dat_way   = hit_way;
        dat_beat  = pa.beat;
        dat_wval  = cpu_wdata;
        case (state_q)
            ST_IDLE: begin
                cpu_ready = serve_hit;
                dat_we    = serve_hit && cpu_we;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = join_addr(wbtag_q, pa.idx, beat_q);
                mem_wdata = data_q[pa.idx][vict_q][beat_q];
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = join_addr(pa.tag, pa.idx, beat_q);
                dat_we    = mem_valid;
                dat_way   = vict_q;
                dat_beat  = beat_q;
                dat_wval  = mem_rdata;
            end
            ST_SINGLE: begin
                mem_req   = 1'b1;
                mem_we    = cpu_we;
                mem_addr  = {cpu_addr[AW-1:BYTE_W], {BYTE_W{1'b0}}};
                mem_wdata = cpu_wdata;
                cpu_ready = mem_valid;
                cpu_rdata = mem_rdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            vict_q  <= '0;
            wbtag_q <= '0;
            inv_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (inv_all) begin
                        state_q <= ST_INV;
                        inv_q   <= '0;
                    end else if (cpu_req && !hit) begin
                        beat_q <= '0;
                        if (all_locked) begin
                            state_q <= ST_SINGLE;
                        end else begin
                            vict_q <= victim;
                            if (valid_vec[victim] && dirty_vec[victim]) begin
                                wbtag_q <= tag_vec[victim];
                                state_q <= ST_WB;
                            end else begin
                                state_q <= ST_FILL;
                            end
                        end
                    end
                end
                ST_WB: if (mem_valid) begin
                    beat_q <= last_beat ? '0 : beat_q + beat_t'(1);
                    if (last_beat) state_q <= ST_FILL;
                end
                ST_FILL: if (mem_valid) begin
                    beat_q <= last_beat ? '0 : beat_q + beat_t'(1);
                    if (last_beat) state_q <= ST_IDLE;
                end
                ST_SINGLE: if (mem_valid) state_q <= ST_IDLE;
                ST_INV: begin
                    inv_q <= inv_q + idx_t'(1);
                    if (inv_q == idx_t'(SETS - 1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wlc_checker.sv
module wlc_checker
    import wlc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_burst,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_valid,
    input logic [LOCK_W-1:0] lock_ways,
    input logic              inv_busy
);
    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mem_req && !cpu_ready);

    assert_sweep_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        inv_busy |-> !mem_req && !cpu_ready);

    assert_beat_hold_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_burst));

    assert_single_when_locked_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && $past(lock_ways) >= LOCK_W'(WAYS) |-> !mem_burst);

    assert_burst_when_free_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && $past(lock_ways) < LOCK_W'(WAYS) |-> mem_burst);
endmodule

bind wlcache wlc_checker u_chk (
    .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_burst(mem_burst), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .lock_ways(lock_ways), .inv_busy(inv_busy)
);

// File: tb/sim_wlcache.sv
`timescale 1ns/1ps
module sim_wlcache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, inv_all = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [63:0] cpu_wdata = '0, cpu_rdata, mem_wdata, mem_rdata;
    logic        cpu_ready, mem_req, mem_we, mem_burst, mem_valid;
    logic [31:0] mem_addr;
    logic [2:0]  lock_ways = 3'd0;

    always #5 clk = ~clk;

    wlcache u0 (.*);

    typedef struct packed { logic we; logic burst; logic [31:0] addr; logic [63:0] data; } ev_t;
    ev_t         log_q[$];
    logic [63:0] mem_arr [logic [31:0]];
    logic [63:0] ref_mem [logic [31:0]];
    int checks = 0, fails = 0;

    function automatic logic [63:0] init_val(input logic [31:0] a);
        return {a ^ 32'h5a5a_0000, ~a};
    endfunction
    function automatic logic [63:0] mem_rd(input logic [31:0] a);
        return mem_arr.exists(a) ? mem_arr[a] : init_val(a);
    endfunction
    function automatic logic [63:0] expect_rd(input logic [31:0] a);
        logic [31:0] k = {a[31:3], 3'b000};
        return ref_mem.exists(k) ? ref_mem[k] : init_val(k);
    endfunction
    function automatic logic [31:0] mk(input int t, input int s, input int b);
        return {20'(t), 7'(s), 2'(b), 3'b000};
    endfunction

    // memory responder: one beat accepted every other cycle while requested
    always @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_valid <= mem_req && !mem_valid;
            if (mem_req && !mem_valid) mem_rdata <= mem_rd(mem_addr);
            if (mem_req && mem_valid) begin
                log_q.push_back('{mem_we, mem_burst, mem_addr, mem_we ? mem_wdata : mem_rdata});
                if (mem_we) mem_arr[mem_addr] = mem_wdata;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [63:0] wd,
                          output logic [63:0] rd, output int lat);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; lat = 0;
        #1;
        while (!cpu_ready && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        if (we) ref_mem[{a[31:3], 3'b000}] = wd;
    endtask

    task automatic rd_check(input logic [31:0] a, input string tag);
        logic [63:0] d; int l;
        access(1'b0, a, '0, d, l);
        check(d === expect_rd(a), tag, d, expect_rd(a));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] d; int l; logic [31:0] base;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cpu_ready == 1'b0 && mem_req == 1'b0, "R9 reset quiet", {62'd0, cpu_ready, mem_req}, 64'd0);

        // R3 clean fill
        log_q.delete();
        access(1'b0, mk(1, 5, 2), '0, d, l);
        check(d === expect_rd(mk(1, 5, 2)), "R3 fill data", d, expect_rd(mk(1, 5, 2)));
        check(log_q.size() == 4, "R3 fill beat count", 64'(log_q.size()), 64'd4);
        for (int i = 0; i < 4 && i < log_q.size(); i++)
            check(!log_q[i].we && log_q[i].burst && log_q[i].addr == mk(1, 5, 0) + 32'(8 * i),
                  "R3 fill beat order", {31'd0, log_q[i].we, log_q[i].addr}, {32'd0, mk(1, 5, 0) + 32'(8 * i)});

        // R1 hit timing and ignored low bits
        access(1'b0, mk(1, 5, 2), '0, d, l);
        check(l == 0, "R1 hit zero stall", 64'(l), 64'd0);
        access(1'b0, mk(1, 5, 3) | 32'd5, '0, d, l);
        check(l == 0 && d === expect_rd(mk(1, 5, 3)), "R1 beat select", d, expect_rd(mk(1, 5, 3)));

        // R2 write hit stays in cache
        log_q.delete();
        access(1'b1, mk(1, 5, 1), 64'hdead_beef_0000_0001, d, l);
        check(l == 0 && log_q.size() == 0, "R2 write hit no traffic", 64'(log_q.size()), 64'd0);
        rd_check(mk(1, 5, 1), "R2 read after write");

        // R5 LRU among ways of set 5
        rd_check(mk(2, 5, 0), "R5 fill t2");
        rd_check(mk(3, 5, 0), "R5 fill t3");
        rd_check(mk(4, 5, 0), "R5 fill t4");
        rd_check(mk(1, 5, 0), "R5 touch t1");
        log_q.delete();
        rd_check(mk(5, 5, 0), "R5 miss t5");
        check(log_q.size() == 4 && !log_q[0].we, "R5 clean victim", 64'(log_q.size()), 64'd4);
        access(1'b0, mk(1, 5, 0), '0, d, l); check(l == 0, "R5 t1 kept", 64'(l), 64'd0);
        access(1'b0, mk(3, 5, 0), '0, d, l); check(l == 0, "R5 t3 kept", 64'(l), 64'd0);
        access(1'b0, mk(4, 5, 0), '0, d, l); check(l == 0, "R5 t4 kept", 64'(l), 64'd0);
        access(1'b0, mk(5, 5, 0), '0, d, l); check(l == 0, "R5 t5 present", 64'(l), 64'd0);
        access(1'b0, mk(2, 5, 0), '0, d, l); check(l > 0, "R5 t2 evicted", 64'(l), 64'd1);

        // R4 dirty write-back before fill
        access(1'b1, mk(1, 9, 1), 64'h1111_2222_3333_4444, d, l);
        rd_check(mk(2, 9, 0), "R4 fill t2");
        rd_check(mk(3, 9, 0), "R4 fill t3");
        rd_check(mk(4, 9, 0), "R4 fill t4");
        log_q.delete();
        rd_check(mk(5, 9, 0), "R4 miss data");
        check(log_q.size() == 8, "R4 beat count", 64'(log_q.size()), 64'd8);
        if (log_q.size() == 8) begin
            for (int i = 0; i < 4; i++)
                check(log_q[i].we && log_q[i].burst && log_q[i].addr == mk(1, 9, i),
                      "R4 write-back first", {32'd0, log_q[i].addr}, {32'd0, mk(1, 9, i)});
            check(log_q[1].data == 64'h1111_2222_3333_4444, "R4 write-back data", log_q[1].data, 64'h1111_2222_3333_4444);
            check(!log_q[4].we && log_q[4].addr == mk(5, 9, 0), "R4 fill after", {32'd0, log_q[4].addr}, {32'd0, mk(5, 9, 0)});
        end
        rd_check(mk(1, 9, 1), "R4 value reaches memory");

        // R6 lock two ways
        rd_check(mk(1, 20, 0), "R6 fill way0");
        rd_check(mk(2, 20, 0), "R6 fill way1");
        lock_ways = 3'd2;
        for (int t = 3; t <= 8; t++) rd_check(mk(t, 20, 0), "R6 thrash");
        access(1'b0, mk(1, 20, 0), '0, d, l); check(l == 0, "R6 locked t1 resident", 64'(l), 64'd0);
        access(1'b0, mk(2, 20, 0), '0, d, l); check(l == 0, "R6 locked t2 resident", 64'(l), 64'd0);

        // R7 all locked
        lock_ways = 3'd4;
        log_q.delete();
        rd_check(mk(30, 20, 2), "R7 single read data");
        check(log_q.size() == 1 && !log_q[0].burst && !log_q[0].we, "R7 single read beat", 64'(log_q.size()), 64'd1);
        log_q.delete();
        rd_check(mk(30, 20, 2), "R7 repeat data");
        check(log_q.size() == 1, "R7 not allocated", 64'(log_q.size()), 64'd1);
        log_q.delete();
        access(1'b1, mk(30, 20, 3), 64'h7777_0000_7777_0000, d, l);
        check(log_q.size() == 1 && log_q[0].we && !log_q[0].burst && log_q[0].data == 64'h7777_0000_7777_0000,
              "R7 single write", log_q.size() > 0 ? log_q[0].data : 64'd0, 64'h7777_0000_7777_0000);
        rd_check(mk(30, 20, 3), "R7 single write readback");
        log_q.delete();
        access(1'b1, mk(1, 20, 0), 64'habcd_abcd_abcd_abcd, d, l);
        check(l == 0 && log_q.size() == 0, "R7 locked write hit", 64'(l), 64'd0);
        access(1'b0, mk(1, 20, 0), '0, d, l);
        check(l == 0 && d == 64'habcd_abcd_abcd_abcd, "R7 locked write data", d, 64'habcd_abcd_abcd_abcd);

        // R8 invalidate sweep
        lock_ways = 3'd0;
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        ref_mem = mem_arr;
        log_q.delete();
        access(1'b0, mk(1, 20, 0), '0, d, l);
        check(l >= 127, "R8 sweep stall", 64'(l), 64'd127);
        check(d === init_val(mk(1, 20, 0)), "R8 dirty dropped", d, init_val(mk(1, 20, 0)));
        check(log_q.size() == 4, "R8 refill after sweep", 64'(log_q.size()), 64'd4);
        access(1'b0, mk(5, 9, 0), '0, d, l);
        check(l > 0, "R8 other set invalid", 64'(l), 64'd1);

        // random phase: data coherence under lock changes (R2, R6, R7)
        for (int n = 0; n < 1500; n++) begin
            logic we; logic [31:0] a; logic [63:0] wv;
            if (n % 50 == 0) lock_ways = 3'($urandom_range(0, 4));
            we = ($urandom_range(0, 9) < 4);
            a  = mk($urandom_range(0, 7), 3 + $urandom_range(0, 1), $urandom_range(0, 3));
            wv = {$urandom, $urandom};
            if (we) access(1'b1, a, wv, d, l);
            else rd_check(a, "R2 random read");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule